// File: doc/BRIEF.md
# Dual-Rate Framebuffer Memory Arbiter

This block lets a processor-side memory port and a raster scan-out reader share one single-ported asynchronous SRAM that holds a 640x480 picture of 16-bit pixels. The memory side is clocked at twice the bus rate. A bus clock enable (`bus_ce`) marks every second memory clock. Each bus cycle is split into two fixed memory slots. The first memory clock after a `bus_ce` cycle is the video slot. The following memory clock, which is also the next `bus_ce` cycle, is the processor slot. Because the slots are fixed, neither master ever waits on the other, and both see constant latencies.

The video side presents a pixel column and a displayed line. The block adds a programmable vertical scroll offset to the line and wraps the result at the picture height. This lets software move the whole picture vertically by changing one value instead of copying pixel data. A new offset is first held in a staging register. It is promoted to the active offset only while the raster is in vertical blanking, so a frame never shows two offsets. The SRAM strobes and the write data are registered. The data bus is split into an output, an output enable and an input, so that the pad cell can sit at chip level.

Top module: `fb_mem_arbiter`

## Requirements
- R1: While `rst_n` is low and after its release, `cpu_rvalid` and `vid_pvalid` are 0, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are 1, and `sram_dq_oe` is 0.
- R2: Requests are accepted on a `bus_ce` cycle. The following memory clock is the video slot and the clock after that is the processor slot. A slot with no request keeps `sram_cs_n` high, and `sram_we_n` is driven low only in the processor slot.
- R3: A processor write (`cpu_we`=1) drives `cpu_addr` and `cpu_wdata` onto the SRAM in the processor slot, with `sram_we_n` low, `sram_dq_oe` high and `sram_oe_n` high. `sram_dq_oe` is never high together with `sram_oe_n` low.
- R4: A processor read (`cpu_we`=0) accepted at a `bus_ce` edge raises `cpu_rvalid` with the read word on `cpu_rdata` after the third memory clock edge. It is still low after the second edge, and the result is held for two memory clocks.
- R5: A video fetch accepted at a `bus_ce` edge reads the SRAM with `sram_oe_n` low in the video slot. `vid_pvalid` and `vid_pixel` appear after the second memory clock edge and are held for two memory clocks.
- R6: A processor access and a video fetch issued in the same bus cycle are both served, each with the same latency it has when issued alone.
- R7: The video word address is row*640 + `vid_x`, where row = (`vid_y` + active offset) mod 480. An offset of 470 maps line 9 to row 479 and line 20 to row 10.
- R8: A scroll value of 480 or more written through `scroll_wr` is stored reduced by 480, so a value of 500 acts as an offset of 20.
- R9: A scroll value written while `vid_vblank` is low does not change fetch addresses until `vid_vblank` has been high for at least two memory clocks. Outside blanking the active offset stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Bus clock enable, high on every second memory clock |
| cpu_req | input | 1 | Processor access request, sampled on `bus_ce` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 19 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data |
| cpu_rvalid | output | 1 | Processor read data valid |
| vid_fetch | input | 1 | Video pixel fetch request, sampled on `bus_ce` |
| vid_x | input | 10 | Pixel column, 0 to 639 |
| vid_y | input | 9 | Displayed line, 0 to 479 |
| vid_vblank | input | 1 | High during vertical blanking |
| scroll_wr | input | 1 | Load a new scroll value into the staging register |
| scroll_row | input | 9 | Scroll value in lines |
| vid_pixel | output | 16 | Fetched pixel |
| vid_pvalid | output | 1 | Fetched pixel valid |
| sram_addr | output | 19 | SRAM word address |
| sram_dq_o | output | 16 | SRAM write data |
| sram_dq_oe | output | 1 | SRAM data output enable |
| sram_dq_i | input | 16 | SRAM read data |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The hardest case to reach from the ports is the deferred promotion of the scroll value. A value written outside blanking must not affect fetches, and the only way to see this is to fetch a pixel whose row would differ under the new offset. The bench writes the offset with `vid_vblank` low and fetches such a pixel to confirm the old row is still used. It then pulses blanking and repeats the fetch at a line chosen so that the wrapped row differs from the unscrolled one. The wrap boundary at row 479 and the reduction of an out-of-range value are reached in the same way. In each case the SRAM model's contents are preloaded so that every candidate row returns a distinct word.

// File: rtl/fbarb_pkg.sv
package fbarb_pkg;
  // Kind of memory access held for the current slot
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_VRD  = 2'd1,
    ACC_CRD  = 2'd2,
    ACC_CWR  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/fbarb_scroll.sv
module fbarb_scroll #(
  parameter int V_LINES = 480,
  parameter int ROW_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ROW_W-1:0] val,
  input  logic             vblank,
  output logic [ROW_W-1:0] yoff
);
  localparam logic [ROW_W-1:0] LINES_C = ROW_W'(V_LINES);

  logic [ROW_W-1:0] stage_q, stage_d;
  logic [ROW_W-1:0] act_q, act_d;

  // Staging register takes any write; active offset follows only in blanking
  always_comb begin
    stage_d = stage_q;
    if (wr) begin
      stage_d = (val >= LINES_C) ? (val - LINES_C) : val;
    end
    act_d = act_q;
    if (vblank) begin
      act_d = stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign yoff = act_q;
endmodule

// File: rtl/fbarb_vaddr.sv
module fbarb_vaddr #(
  parameter int H_PIXELS = 640,
  parameter int V_LINES  = 480,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 9,
  parameter int ADDR_W   = 19
) (
  input  logic [COL_W-1:0]  x,
  input  logic [ROW_W-1:0]  y,
  input  logic [ROW_W-1:0]  yoff,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ROW_W:0] LINES_C = (ROW_W+1)'(V_LINES);

  logic [ROW_W:0]   sum;
  logic [ROW_W:0]   wrapped;
  logic [ROW_W-1:0] row;

  // Both operands are below V_LINES, so one conditional subtract wraps
  always_comb begin
    sum     = {1'b0, y} + {1'b0, yoff};
    wrapped = (sum >= LINES_C) ? (sum - LINES_C) : sum;
    row     = wrapped[ROW_W-1:0];
    addr    = ADDR_W'(row) * ADDR_W'(H_PIXELS) + ADDR_W'(x);
  end
endmodule

// File: rtl/fbarb_slot.sv
module fbarb_slot
  import fbarb_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce,
  input  logic              vid_go,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic              cpu_go,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output acc_kind_e         kind,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  acc_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              dqoe_q, dqoe_d;
  logic              cs_n_q, cs_n_d;
  logic              oe_n_q, oe_n_d;
  logic              we_n_q, we_n_d;

  // A bus_ce cycle sets up the video slot; the other cycle sets up the CPU slot
  always_comb begin
    kind_d = ACC_NONE;
    addr_d = '0;
    wd_d   = '0;
    if (bus_ce) begin
      if (vid_go) begin
        kind_d = ACC_VRD;
        addr_d = vid_addr;
      end
    end else if (cpu_go) begin
      kind_d = cpu_wr ? ACC_CWR : ACC_CRD;
      addr_d = cpu_addr;
      wd_d   = cpu_wr ? cpu_wdata : '0;
    end
    cs_n_d = (kind_d == ACC_NONE);
    oe_n_d = !((kind_d == ACC_VRD) || (kind_d == ACC_CRD));
    we_n_d = (kind_d != ACC_CWR);
    dqoe_d = (kind_d == ACC_CWR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= ACC_NONE;
      addr_q <= '0;
      wd_q   <= '0;
      dqoe_q <= 1'b0;
      cs_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
    end else begin
      kind_q <= kind_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      dqoe_q <= dqoe_d;
      cs_n_q <= cs_n_d;
      oe_n_q <= oe_n_d;
      we_n_q <= we_n_d;
    end
  end

  assign kind       = kind_q;
  assign sram_addr  = addr_q;
  assign sram_dq_o  = wd_q;
  assign sram_dq_oe = dqoe_q;
  assign sram_cs_n  = cs_n_q;
  assign sram_oe_n  = oe_n_q;
  assign sram_we_n  = we_n_q;
endmodule

// File: rtl/fb_mem_arbiter.sv
module fb_mem_arbiter
  import fbarb_pkg::*;
#(
  parameter int  H_PIXELS = 640,
  parameter int  V_LINES  = 480,
  parameter int  DATA_W   = 16,
  localparam int ADDR_W   = $clog2(H_PIXELS * V_LINES),
  localparam int COL_W    = $clog2(H_PIXELS),
  localparam int ROW_W    = $clog2(V_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic              vid_fetch,
  input  logic [COL_W-1:0]  vid_x,
  input  logic [ROW_W-1:0]  vid_y,
  input  logic              vid_vblank,
  input  logic              scroll_wr,
  input  logic [ROW_W-1:0]  scroll_row,
  output logic [DATA_W-1:0] vid_pixel,
  output logic              vid_pvalid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  logic [ROW_W-1:0]  yoff_act;
  logic [ADDR_W-1:0] vaddr;
  acc_kind_e         slot_kind;

  // Processor request held for the CPU slot of the same bus cycle
  logic              pend_go_q, pend_go_d;
  logic              pend_wr_q, pend_wr_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic [DATA_W-1:0] pend_wd_q, pend_wd_d;

  // Returned data registers
  logic [DATA_W-1:0] crd_q, crd_d;
  logic              crv_q, crv_d;
  logic [DATA_W-1:0] pix_q, pix_d;
  logic              pxv_q, pxv_d;

  fbarb_scroll #(
    .V_LINES (V_LINES),
    .ROW_W   (ROW_W)
  ) u_scroll (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (scroll_wr),
    .val    (scroll_row),
    .vblank (vid_vblank),
    .yoff   (yoff_act)
  );

  fbarb_vaddr #(
    .H_PIXELS (H_PIXELS),
    .V_LINES  (V_LINES),
    .COL_W    (COL_W),
    .ROW_W    (ROW_W),
    .ADDR_W   (ADDR_W)
  ) u_vaddr (
    .x    (vid_x),
    .y    (vid_y),
    .yoff (yoff_act),
    .addr (vaddr)
  );

  fbarb_slot #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ce     (bus_ce),
    .vid_go     (vid_fetch),
    .vid_addr   (vaddr),
    .cpu_go     (pend_go_q),
    .cpu_wr     (pend_wr_q),
    .cpu_addr   (pend_addr_q),
    .cpu_wdata  (pend_wd_q),
    .kind       (slot_kind),
    .sram_addr  (sram_addr),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe),
    .sram_cs_n  (sram_cs_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n)
  );

  always_comb begin
    pend_go_d   = pend_go_q;
    pend_wr_d   = pend_wr_q;
    pend_addr_d = pend_addr_q;
    pend_wd_d   = pend_wd_q;
    if (bus_ce) begin
      pend_go_d   = cpu_req;
      pend_wr_d   = cpu_we;
      pend_addr_d = cpu_addr;
      pend_wd_d   = cpu_wdata;
    end
  end

  // The video slot runs while bus_ce is low, the CPU slot while it is high
  always_comb begin
    pix_d = pix_q;
    pxv_d = pxv_q;
    crd_d = crd_q;
    crv_d = crv_q;
    if (!bus_ce) begin
      pxv_d = (slot_kind == ACC_VRD);
      if (slot_kind == ACC_VRD) begin
        pix_d = sram_dq_i;
      end
    end else begin
      crv_d = (slot_kind == ACC_CRD);
      if (slot_kind == ACC_CRD) begin
        crd_d = sram_dq_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_go_q   <= 1'b0;
      pend_wr_q   <= 1'b0;
      pend_addr_q <= '0;
      pend_wd_q   <= '0;
      pix_q       <= '0;
      pxv_q       <= 1'b0;
      crd_q       <= '0;
      crv_q       <= 1'b0;
    end else begin
      pend_go_q   <= pend_go_d;
      pend_wr_q   <= pend_wr_d;
      pend_addr_q <= pend_addr_d;
      pend_wd_q   <= pend_wd_d;
      pix_q       <= pix_d;
      pxv_q       <= pxv_d;
      crd_q       <= crd_d;
      crv_q       <= crv_d;
    end
  end

  assign cpu_rdata  = crd_q;
  assign cpu_rvalid = crv_q;
  assign vid_pixel  = pix_q;
  assign vid_pvalid = pxv_q;
endmodule

// File: rtl/fbarb_checker.sv
module fbarb_checker #(
  parameter int ADDR_W  = 19,
  parameter int ROW_W   = 9,
  parameter int PIXELS  = 307200,
  parameter int V_LINES = 480
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ce,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              vid_fetch,
  input logic              vid_vblank,
  input logic              cpu_rvalid,
  input logic              vid_pvalid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_dq_oe,
  input logic              sram_cs_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [ROW_W-1:0]  yoff_act
);
  AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && !vid_fetch) |=> sram_cs_n); // R2
  AST_WE_CPU_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> bus_ce); // R2
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_we_n)); // R3
  AST_CPU_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && cpu_req && !cpu_we) |=> ##2 cpu_rvalid); // R4
  AST_VID_RD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && vid_fetch) |=> (!sram_cs_n && !sram_oe_n && sram_we_n)); // R5
  AST_VID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && vid_fetch) |=> ##1 vid_pvalid); // R5
  AST_BOTH_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && vid_fetch && cpu_req) |=> ##1 !sram_cs_n); // R6
  AST_VID_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce && !sram_oe_n) |-> (int'(sram_addr) < PIXELS)); // R7
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(yoff_act) < V_LINES); // R8
  AST_SCROLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_vblank |=> $stable(yoff_act)); // R9
endmodule

bind fb_mem_arbiter fbarb_checker #(
  .ADDR_W  (ADDR_W),
  .ROW_W   (ROW_W),
  .PIXELS  (H_PIXELS * V_LINES),
  .V_LINES (V_LINES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_ce     (bus_ce),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .vid_fetch  (vid_fetch),
  .vid_vblank (vid_vblank),
  .cpu_rvalid (cpu_rvalid),
  .vid_pvalid (vid_pvalid),
  .sram_addr  (sram_addr),
  .sram_dq_oe (sram_dq_oe),
  .sram_cs_n  (sram_cs_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .yoff_act   (yoff_act)
);

// File: tb/fb_mem_arbiter_bench.sv
module fb_mem_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 640;
  localparam int H = 480;

  logic        clk;
  logic        rst_n;
  logic        bus_ce;
  logic        cpu_req, cpu_we;
  logic [18:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        cpu_rvalid;
  logic        vid_fetch;
  logic [9:0]  vid_x;
  logic [8:0]  vid_y;
  logic        vid_vblank, scroll_wr;
  logic [8:0]  scroll_row;
  logic [15:0] vid_pixel;
  logic        vid_pvalid;
  logic [18:0] sram_addr;
  logic [15:0] sram_dq_o, sram_dq_i;
  logic        sram_dq_oe, sram_cs_n, sram_oe_n, sram_we_n;

  int checks = 0;
  int errors = 0;
  int bad_strobe = 0;
  int cycles = 0;
  logic [15:0] mem [int];

  fb_mem_arbiter u_fb_mem_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .vid_fetch(vid_fetch), .vid_x(vid_x), .vid_y(vid_y),
    .vid_vblank(vid_vblank), .scroll_wr(scroll_wr), .scroll_row(scroll_row),
    .vid_pixel(vid_pixel), .vid_pvalid(vid_pvalid),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) bus_ce <= 1'b0;
    else        bus_ce <= ~bus_ce;
  end

  function automatic logic [15:0] word_at(int a);
    if (mem.exists(a)) return mem[a];
    return 16'(a) ^ 16'h5A3C;
  endfunction

  function automatic int pix_addr(int x, int y, int off);
    return ((y + off) % H) * W + x;
  endfunction

  // Asynchronous SRAM model: strobes settle at the rising edge, act at the falling one
  always @(negedge clk) begin
    cycles++;
    if (!sram_cs_n && !sram_oe_n) sram_dq_i <= word_at(int'(sram_addr));
    else                          sram_dq_i <= 16'h0000;
    if (!sram_cs_n && !sram_we_n && sram_dq_oe) mem[int'(sram_addr)] = sram_dq_o;
    if (rst_n && !sram_we_n && !bus_ce) bad_strobe++;
    if (rst_n && sram_dq_oe && !sram_oe_n) bad_strobe++;
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=below 100000", cycles);
      finish_run();
    end
  end

  // One bus cycle of stimulus, sampled after each of the next three memory edges
  task automatic issue(input logic creq, input logic cwe, input int caddr,
                       input logic [15:0] cwd, input logic vf, input int x, input int y,
                       output logic pv1, output logic pv2, output logic [15:0] px2,
                       output logic rv2, output logic rv3, output logic [15:0] rd3);
    do @(negedge clk); while (bus_ce !== 1'b1);
    cpu_req = creq; cpu_we = cwe; cpu_addr = 19'(caddr); cpu_wdata = cwd;
    vid_fetch = vf; vid_x = 10'(x); vid_y = 9'(y);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0; vid_fetch = 1'b0;
    pv1 = vid_pvalid;
    @(negedge clk);
    pv2 = vid_pvalid; px2 = vid_pixel; rv2 = cpu_rvalid;
    @(negedge clk);
    rv3 = cpu_rvalid; rd3 = cpu_rdata;
  endtask

  task automatic set_scroll(input int v, input logic blank);
    @(negedge clk);
    scroll_wr = 1'b1; scroll_row = 9'(v);
    @(negedge clk);
    scroll_wr = 1'b0;
    if (blank) begin
      vid_vblank = 1'b1;
      repeat (3) @(negedge clk);
      vid_vblank = 1'b0;
    end
  endtask

  task automatic fetch_check(string req, int x, int y, int off);
    logic pv1, pv2, rv2, rv3;
    logic [15:0] px2, rd3;
    issue(1'b0, 1'b0, 0, 16'h0, 1'b1, x, y, pv1, pv2, px2, rv2, rv3, rd3);
    check(req, {31'b0, pv2}, 32'd1);
    check(req, {16'b0, px2}, {16'b0, word_at(pix_addr(x, y, off))});
  endtask

  task automatic t_reset();
    check("R1 cpu_rvalid", {31'b0, cpu_rvalid}, 32'd0);
    check("R1 vid_pvalid", {31'b0, vid_pvalid}, 32'd0);
    check("R1 strobes", {28'b0, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe}, 32'hE);
  endtask

  task automatic t_cpu_write_read();
    logic pv1, pv2, rv2, rv3;
    logic [15:0] px2, rd3;
    issue(1'b1, 1'b1, 1234, 16'hBEEF, 1'b0, 0, 0, pv1, pv2, px2, rv2, rv3, rd3);
    check("R3 write lands", {16'b0, word_at(1234)}, 32'hBEEF);
    check("R3 no read valid on write", {31'b0, rv3}, 32'd0);
    issue(1'b1, 1'b0, 1234, 16'h0, 1'b0, 0, 0, pv1, pv2, px2, rv2, rv3, rd3);
    check("R4 rvalid low after two edges", {31'b0, rv2}, 32'd0);
    check("R4 rvalid after three edges", {31'b0, rv3}, 32'd1);
    check("R4 rdata", {16'b0, rd3}, 32'hBEEF);
    @(negedge clk);
    check("R4 rvalid held", {31'b0, cpu_rvalid}, 32'd1);
  endtask

  task automatic t_video_plain();
    logic pv1, pv2, rv2, rv3;
    logic [15:0] px2, rd3;
    issue(1'b1, 1'b1, pix_addr(5, 3, 0), 16'h1357, 1'b0, 0, 0, pv1, pv2, px2, rv2, rv3, rd3);
    issue(1'b0, 1'b0, 0, 16'h0, 1'b1, 5, 3, pv1, pv2, px2, rv2, rv3, rd3);
    check("R5 pvalid low after one edge", {31'b0, pv1}, 32'd0);
    check("R5 pvalid after two edges", {31'b0, pv2}, 32'd1);
    check("R5 R7 pixel row 3", {16'b0, px2}, 32'h1357);
    check("R5 pvalid held", {31'b0, rv3 | vid_pvalid}, 32'd1);
    fetch_check("R7 last pixel", 639, 479, 0);
  endtask

  task automatic t_idle();
    logic seen;
    seen = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (!sram_cs_n) seen = 1'b1;
    end
    check("R2 idle slots keep cs_n high", {31'b0, seen}, 32'd0);
  endtask

  task automatic t_concurrent();
    logic pv1, pv2, rv2, rv3;
    logic [15:0] px2, rd3;
    issue(1'b1, 1'b1, 777, 16'hA001, 1'b1, 639, 0, pv1, pv2, px2, rv2, rv3, rd3);
    check("R6 write served", {16'b0, word_at(777)}, 32'hA001);
    check("R6 video served", {16'b0, px2}, {16'b0, word_at(639)});
    check("R6 video latency", {31'b0, pv2}, 32'd1);
    issue(1'b1, 1'b0, 777, 16'h0, 1'b1, 5, 3, pv1, pv2, px2, rv2, rv3, rd3);
    check("R6 read served", {16'b0, rd3}, 32'hA001);
    check("R6 read latency", {30'b0, rv2, rv3}, 32'd1);
    check("R6 pixel", {16'b0, px2}, 32'h1357);
  endtask

  task automatic t_scroll_gate();
    set_scroll(10, 1'b0);
    fetch_check("R9 offset not applied outside blanking", 5, 3, 0);
    vid_vblank = 1'b1;
    repeat (3) @(negedge clk);
    vid_vblank = 1'b0;
    fetch_check("R9 R7 offset applied after blanking", 5, 3, 10);
  endtask

  task automatic t_scroll_wrap();
    set_scroll(470, 1'b1);
    fetch_check("R7 wrap to row 479", 7, 9, 470);
    fetch_check("R7 wrap to row 10", 7, 20, 470);
  endtask

  task automatic t_scroll_reduce();
    set_scroll(500, 1'b1);
    fetch_check("R8 value 500 acts as 20", 0, 0, 20);
    set_scroll(479, 1'b1);
    fetch_check("R8 R7 offset 479 line 1 row 0", 3, 1, 479);
  endtask

  initial begin
    rst_n = 1'b0; bus_ce = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    vid_fetch = 1'b0; vid_x = '0; vid_y = '0; vid_vblank = 1'b0;
    scroll_wr = 1'b0; scroll_row = '0; sram_dq_i = '0;
    // Distinct words in every row a scroll test can land on
    for (int r = 0; r < H; r++) begin
      mem[r * W + 5]  = 16'(16'h2000 + r);
      mem[r * W + 7]  = 16'(16'h3000 + r);
      mem[r * W]      = 16'(16'h4000 + r);
      mem[r * W + 3]  = 16'(16'h6000 + r);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_cpu_write_read();
    t_video_plain();
    t_idle();
    t_concurrent();
    t_scroll_gate();
    t_scroll_wrap();
    t_scroll_reduce();
    check("R2 R3 write strobe and bus direction", bad_strobe, 0);
    finish_run();
  end
endmodule